// File: doc/BRIEF.md
# SPI Transmit/Receive Queue Pair with Threshold and Timeout Status

This block sits between a serial-peripheral register file and its shift engine. It holds two independent word queues: the transmit queue, which software fills and the engine drains, and the receive queue, which the engine fills and software drains. Each queue reports its occupancy and its empty and full state, and can be emptied at once by a single-cycle clear strobe.

Around the queues the block derives the status that software and the interrupt controller need. There are two programmable fill-level compares with opposite senses, a sticky flag for words lost to a full receive queue, and a receive timeout that fires when unread data has been waiting for a fixed number of serial clock periods in master mode. It also produces one interrupt line per source, each masked by its own enable. In master mode it generates the busy indication: busy rises on any transmit write and falls once the transmit queue is empty and the engine reports idle.

Top module: `spi_fifo_pair`

## Requirements
- R1: Each queue returns words in the order they were accepted. A pop of a non-empty queue places the oldest word on its read-data port in the cycle after the pop. A pop of an empty queue leaves the read data and the count unchanged.
- R2: The count ports give the number of stored words, 0 to DEPTH (default 8). Empty is 1 exactly at count 0 and full is 1 exactly at count DEPTH. A transmit push while full is dropped and the count does not change.
- R3: A receive push while the receive queue is full is discarded, the count and stored words stay unchanged, and the sticky overrun flag becomes 1 in the next cycle. A one-cycle pulse on `ovr_clr` returns the flag to 0; when a drop and `ovr_clr` coincide, the flag is set.
- R4: `rx_thr_sts` is 1 exactly when `rx_count` is strictly greater than `rx_thresh`.
- R5: `tx_thr_sts` is 1 exactly when `tx_count` is less than or equal to `tx_thresh`.
- R6: A pulse on `rx_clr` (or `tx_clr`) empties that queue in the next cycle: count 0, empty 1, full 0. The clear takes priority over a push or pop in the same cycle.
- R7: In master mode, with the receive queue non-empty, the timeout flag becomes 1 at the clock edge that samples the 64th `sclk_tick` pulse since the last receive push, pop or clear. With the queue empty, or with `master_mode` low, the flag never sets.
- R8: Any receive pop, and a pulse on `tmo_clr`, clear the timeout flag in the next cycle. After the flag fires, the count holds, so the flag cannot fire again until a receive push or pop restarts the count.
- R9: `irq[i]` equals status source i AND `irq_en[i]`, with bit 0 the receive threshold, bit 1 the transmit threshold, bit 2 the overrun flag and bit 3 the timeout flag.
- R10: In master mode, `busy` is 1 from the cycle after a transmit push until the cycle after `tx_empty` and `engine_idle` are both 1. With `master_mode` low, `busy` is 0 in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_mode | input | 1 | 1 selects master operation |
| engine_idle | input | 1 | Shift engine reports no word in flight |
| sclk_tick | input | 1 | One-cycle pulse per serial clock period |
| tx_push | input | 1 | Write a word into the transmit queue |
| tx_wdata | input | 32 | Transmit write data |
| tx_pop | input | 1 | Engine takes a word from the transmit queue |
| tx_rdata | output | 32 | Word taken by the last transmit pop |
| tx_clr | input | 1 | Empty the transmit queue |
| rx_push | input | 1 | Engine delivers a received word |
| rx_wdata | input | 32 | Received word |
| rx_pop | input | 1 | Software reads the receive queue |
| rx_rdata | output | 32 | Word returned by the last receive pop |
| rx_clr | input | 1 | Empty the receive queue |
| tx_count | output | 4 | Transmit queue occupancy |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_count | output | 4 | Receive queue occupancy |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| tx_thresh | input | 3 | Transmit fill-level threshold |
| rx_thresh | input | 3 | Receive fill-level threshold |
| tx_thr_sts | output | 1 | Transmit count at or below threshold |
| rx_thr_sts | output | 1 | Receive count above threshold |
| ovr_clr | input | 1 | Write-one clear of the overrun flag |
| ovr_flag | output | 1 | Sticky receive overrun flag |
| tmo_clr | input | 1 | Write-one clear of the timeout flag |
| tmo_flag | output | 1 | Receive timeout flag |
| irq_en | input | 4 | Per-source interrupt enables |
| irq | output | 4 | Per-source interrupt requests |
| busy | output | 1 | Master-mode transfer busy indication |

## Verification
Counts, empty, full, read data, the overrun and timeout flags and `busy` are all registered, so each is due one clock after the edge that samples its stimulus. The bench drives each stimulus just after an edge, waits for exactly one edge, and samples one time unit later. The threshold status bits and `irq` are combinational from registered counts, flags and the directly driven thresholds and enables, so they are checked in the same sample slot as the counts. The timeout is counted in `sclk_tick` pulses: the bench applies exactly 63 pulses and checks that the flag is still low, then applies the 64th and checks that it is high after that pulse's edge.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
   // interrupt source bit positions on irq / irq_en
   localparam int IRQ_RX_THR = 0;
   localparam int IRQ_TX_THR = 1;
   localparam int IRQ_OVR    = 2;
   localparam int IRQ_TMO    = 3;
   localparam int IRQ_NUM    = 4;
endpackage

// File: rtl/sfp_fifo.sv
module sfp_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     push,
   input  logic [DW-1:0]            wdata,
   input  logic                     pop,
   output logic [DW-1:0]            rdata,
   output logic [$clog2(DEPTH):0]   count,
   output logic                     empty,
   output logic                     full,
   output logic                     drop
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("sfp_fifo: DEPTH must be at least 2");
      end
      if (DW < 1) begin : g_bad_width
         $error("sfp_fifo: DW must be at least 1");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_n, rp_n;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push & ~full & ~clr;
   assign do_pop  = pop & ~empty & ~clr;
   assign drop    = push & full & ~clr;
   assign count   = cnt;

   // pointer advance: free wrap for power-of-two depths, explicit wrap otherwise
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         always_comb begin
            wp_n = wp + 1'b1;
            rp_n = rp + 1'b1;
         end
      end else begin : g_wrap
         always_comb begin
            wp_n = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            rp_n = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         cnt   <= '0;
         rdata <= '0;
      end else if (clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_n;
         if (do_pop) begin
            rp    <= rp_n;
            rdata <= mem[rp];
         end
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end
endmodule

// File: rtl/sfp_rx_timer.sv
module sfp_rx_timer #(
   parameter int TICKS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic q_empty,
   input  logic restart,
   input  logic tick,
   input  logic rd_clr,
   input  logic sw_clr,
   output logic flag
);
   localparam int TW = $clog2(TICKS + 1);

   generate
      if (TICKS < 2) begin : g_bad_ticks
         $error("sfp_rx_timer: TICKS must be at least 2");
      end
   endgenerate

   logic [TW-1:0] cnt;
   logic          armed;

   assign armed = enable & ~q_empty & ~restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         flag <= 1'b0;
      end else begin
         if (!armed) cnt <= '0;
         else if (tick && cnt != TW'(TICKS)) cnt <= cnt + 1'b1;

         if (rd_clr || sw_clr) flag <= 1'b0;
         else if (armed && tick && cnt == TW'(TICKS - 1)) flag <= 1'b1;
      end
   end
endmodule

// File: rtl/sfp_status.sv
module sfp_status
   import sfp_pkg::*;
#(
   parameter int CW = 4,
   parameter int TW = 3
) (
   input  logic [CW-1:0]      rx_count,
   input  logic [CW-1:0]      tx_count,
   input  logic [TW-1:0]      rx_thresh,
   input  logic [TW-1:0]      tx_thresh,
   input  logic               ovr,
   input  logic               tmo,
   input  logic [IRQ_NUM-1:0] irq_en,
   output logic               rx_sts,
   output logic               tx_sts,
   output logic [IRQ_NUM-1:0] irq
);
   logic [IRQ_NUM-1:0] src;

   // opposite senses: receive above level, transmit at or below level
   assign rx_sts = rx_count >  CW'(rx_thresh);
   assign tx_sts = tx_count <= CW'(tx_thresh);

   always_comb begin
      src             = '0;
      src[IRQ_RX_THR] = rx_sts;
      src[IRQ_TX_THR] = tx_sts;
      src[IRQ_OVR]    = ovr;
      src[IRQ_TMO]    = tmo;
   end

   generate
      for (genvar i = 0; i < IRQ_NUM; i++) begin : g_gate
         assign irq[i] = src[i] & irq_en[i];
      end
   endgenerate
endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
   import sfp_pkg::*;
#(
   parameter int DW        = 32,
   parameter int DEPTH     = 8,
   parameter int TMO_TICKS = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    master_mode,
   input  logic                    engine_idle,
   input  logic                    sclk_tick,
   input  logic                    tx_push,
   input  logic [DW-1:0]           tx_wdata,
   input  logic                    tx_pop,
   output logic [DW-1:0]           tx_rdata,
   input  logic                    tx_clr,
   input  logic                    rx_push,
   input  logic [DW-1:0]           rx_wdata,
   input  logic                    rx_pop,
   output logic [DW-1:0]           rx_rdata,
   input  logic                    rx_clr,
   output logic [$clog2(DEPTH):0]  tx_count,
   output logic                    tx_empty,
   output logic                    tx_full,
   output logic [$clog2(DEPTH):0]  rx_count,
   output logic                    rx_empty,
   output logic                    rx_full,
   input  logic [$clog2(DEPTH)-1:0] tx_thresh,
   input  logic [$clog2(DEPTH)-1:0] rx_thresh,
   output logic                    tx_thr_sts,
   output logic                    rx_thr_sts,
   input  logic                    ovr_clr,
   output logic                    ovr_flag,
   input  logic                    tmo_clr,
   output logic                    tmo_flag,
   input  logic [3:0]              irq_en,
   output logic [3:0]              irq,
   output logic                    busy
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   generate
      if (IRQ_NUM != 4) begin : g_bad_irq
         $error("spi_fifo_pair: irq port width must match IRQ_NUM");
      end
   endgenerate

   logic tx_drop_unused, rx_drop;

   sfp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(tx_clr),
      .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_rdata),
      .count(tx_count), .empty(tx_empty), .full(tx_full), .drop(tx_drop_unused)
   );

   sfp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr),
      .push(rx_push), .wdata(rx_wdata), .pop(rx_pop), .rdata(rx_rdata),
      .count(rx_count), .empty(rx_empty), .full(rx_full), .drop(rx_drop)
   );

   sfp_rx_timer #(.TICKS(TMO_TICKS)) u_tmo (
      .clk(clk), .rst_n(rst_n), .enable(master_mode), .q_empty(rx_empty),
      .restart(rx_push | rx_pop | rx_clr), .tick(sclk_tick),
      .rd_clr(rx_pop), .sw_clr(tmo_clr), .flag(tmo_flag)
   );

   sfp_status #(.CW(CW), .TW(AW)) u_sts (
      .rx_count(rx_count), .tx_count(tx_count),
      .rx_thresh(rx_thresh), .tx_thresh(tx_thresh),
      .ovr(ovr_flag), .tmo(tmo_flag), .irq_en(irq_en),
      .rx_sts(rx_thr_sts), .tx_sts(tx_thr_sts), .irq(irq)
   );

   // sticky overrun: a new drop wins over a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovr_flag <= 1'b0;
      else if (rx_drop) ovr_flag <= 1'b1;
      else if (ovr_clr) ovr_flag <= 1'b0;
   end

   // master busy: raised by any transmit write, dropped once drained and idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy <= 1'b0;
      else        busy <= master_mode & (tx_push | (busy & ~(tx_empty & engine_idle)));
   end
endmodule

// File: rtl/sfp_checker.sv
module sfp_checker #(
   parameter int DEPTH = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   master_mode,
   input logic                   tx_push,
   input logic                   tx_clr,
   input logic                   rx_push,
   input logic                   rx_pop,
   input logic                   rx_clr,
   input logic [$clog2(DEPTH):0] tx_count,
   input logic [$clog2(DEPTH):0] rx_count,
   input logic                   tx_empty,
   input logic                   tx_full,
   input logic                   rx_empty,
   input logic                   rx_full,
   input logic                   ovr_flag,
   input logic                   tmo_flag,
   input logic [3:0]             irq_en,
   input logic [3:0]             irq,
   input logic                   busy
);
   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count <= ($clog2(DEPTH)+1)'(DEPTH)) && (tx_count <= ($clog2(DEPTH)+1)'(DEPTH)));

   assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_empty && rx_full) && !(tx_empty && tx_full));

   assert_overrun_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_full && !rx_clr) |=> ovr_flag);

   assert_overrun_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_full && !rx_pop && !rx_clr) |=> $stable(rx_count));

   assert_rx_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_clr |=> (rx_empty && !rx_full));

   assert_tx_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_clr |=> (tx_empty && !tx_full));

   assert_tmo_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_flag) |-> ($past(master_mode) && !$past(rx_empty)));

   assert_read_clears_tmo_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop |=> !tmo_flag);

   assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq & ~irq_en) == 4'b0000);

   assert_busy_on_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && tx_push) |=> busy);

   assert_busy_slave_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !master_mode |=> !busy);
endmodule

bind spi_fifo_pair sfp_checker #(.DEPTH(DEPTH)) chk_i (
   .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
   .tx_push(tx_push), .tx_clr(tx_clr),
   .rx_push(rx_push), .rx_pop(rx_pop), .rx_clr(rx_clr),
   .tx_count(tx_count), .rx_count(rx_count),
   .tx_empty(tx_empty), .tx_full(tx_full),
   .rx_empty(rx_empty), .rx_full(rx_full),
   .ovr_flag(ovr_flag), .tmo_flag(tmo_flag),
   .irq_en(irq_en), .irq(irq), .busy(busy)
);

// File: tb/spi_fifo_pair_tb_top.sv
`timescale 1ns/1ps
module spi_fifo_pair_tb_top;
   localparam int DW    = 32;
   localparam int DEPTH = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n, master_mode, engine_idle, sclk_tick;
   logic          tx_push, tx_pop, tx_clr, rx_push, rx_pop, rx_clr;
   logic [DW-1:0] tx_wdata, rx_wdata, tx_rdata, rx_rdata;
   logic [3:0]    tx_count, rx_count;
   logic          tx_empty, tx_full, rx_empty, rx_full;
   logic [2:0]    tx_thresh, rx_thresh;
   logic          tx_thr_sts, rx_thr_sts, ovr_clr, ovr_flag, tmo_clr, tmo_flag, busy;
   logic [3:0]    irq_en, irq;

   spi_fifo_pair #(.DW(DW), .DEPTH(DEPTH), .TMO_TICKS(64)) dut_i (
      .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .engine_idle(engine_idle),
      .sclk_tick(sclk_tick),
      .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata), .tx_clr(tx_clr),
      .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_clr(rx_clr),
      .tx_count(tx_count), .tx_empty(tx_empty), .tx_full(tx_full),
      .rx_count(rx_count), .rx_empty(rx_empty), .rx_full(rx_full),
      .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
      .tx_thr_sts(tx_thr_sts), .rx_thr_sts(rx_thr_sts),
      .ovr_clr(ovr_clr), .ovr_flag(ovr_flag), .tmo_clr(tmo_clr), .tmo_flag(tmo_flag),
      .irq_en(irq_en), .irq(irq), .busy(busy)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // inputs change 1 ns after an edge; outputs sampled 1 ns after the next edge
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic tx_put(input logic [31:0] d);
      tx_push = 1'b1; tx_wdata = d; step(); tx_push = 1'b0;
   endtask
   task automatic tx_get();
      tx_pop = 1'b1; step(); tx_pop = 1'b0;
   endtask
   task automatic rx_put(input logic [31:0] d);
      rx_push = 1'b1; rx_wdata = d; step(); rx_push = 1'b0;
   endtask
   task automatic rx_get();
      rx_pop = 1'b1; step(); rx_pop = 1'b0;
   endtask
   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         sclk_tick = 1'b1; step(); sclk_tick = 1'b0; step();
      end
   endtask

   function automatic logic [31:0] pat(input int k, input logic [31:0] salt);
      return salt ^ (32'h0103_0507 * (k + 1));
   endfunction

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; master_mode = 1'b0; engine_idle = 1'b1; sclk_tick = 1'b0;
      tx_push = 1'b0; tx_pop = 1'b0; tx_clr = 1'b0; tx_wdata = '0;
      rx_push = 1'b0; rx_pop = 1'b0; rx_clr = 1'b0; rx_wdata = '0;
      tx_thresh = 3'd0; rx_thresh = 3'd0; ovr_clr = 1'b0; tmo_clr = 1'b0; irq_en = 4'h0;
      step(); step(); step();
      rst_n = 1'b1;
      step();

      // reset state (R1, R2, R5, R9, R10)
      chk("R2", "reset tx_empty", 32'(tx_empty), 1);
      chk("R2", "reset rx_empty", 32'(rx_empty), 1);
      chk("R2", "reset counts", {tx_count, rx_count}, 0);
      chk("R1", "reset rx_rdata", rx_rdata, 0);
      chk("R5", "reset tx_thr_sts", 32'(tx_thr_sts), 1);
      chk("R9", "reset irq", 32'(irq), 0);
      chk("R10", "reset busy", 32'(busy), 0);
      chk("R3", "reset flags", {ovr_flag, tmo_flag}, 0);

      // transmit sweep over every count and threshold (R2, R5), slave mode
      for (int k = 0; k <= DEPTH; k++) begin
         chk("R2", $sformatf("tx_count at %0d", k), 32'(tx_count), k);
         chk("R2", $sformatf("tx_empty at %0d", k), 32'(tx_empty), 32'(k == 0));
         chk("R2", $sformatf("tx_full at %0d", k), 32'(tx_full), 32'(k == DEPTH));
         for (int t = 0; t < 8; t++) begin
            tx_thresh = 3'(t);
            step();
            chk("R5", $sformatf("tx_thr_sts cnt=%0d thr=%0d", k, t), 32'(tx_thr_sts), 32'(k <= t));
         end
         if (k < DEPTH) tx_put(pat(k, 32'hA000_0000));
      end
      tx_put(32'hDEAD_BEEF);
      chk("R2", "tx push while full dropped", 32'(tx_count), DEPTH);
      for (int k = 0; k < DEPTH; k++) begin
         tx_get();
         chk("R1", $sformatf("tx order %0d", k), tx_rdata, pat(k, 32'hA000_0000));
      end
      chk("R2", "tx drained empty", 32'(tx_empty), 1);

      // receive sweep (R2, R4)
      for (int k = 0; k <= DEPTH; k++) begin
         chk("R2", $sformatf("rx_count at %0d", k), 32'(rx_count), k);
         chk("R2", $sformatf("rx_full at %0d", k), 32'(rx_full), 32'(k == DEPTH));
         for (int t = 0; t < 8; t++) begin
            rx_thresh = 3'(t);
            step();
            chk("R4", $sformatf("rx_thr_sts cnt=%0d thr=%0d", k, t), 32'(rx_thr_sts), 32'(k > t));
         end
         if (k < DEPTH) rx_put(pat(k, 32'h5000_0000));
      end

      // overrun (R3)
      chk("R3", "ovr before overflow", 32'(ovr_flag), 0);
      rx_put(32'hBAD0_BAD0);
      chk("R3", "ovr after push while full", 32'(ovr_flag), 1);
      chk("R3", "rx_count after drop", 32'(rx_count), DEPTH);
      for (int k = 0; k < DEPTH; k++) begin
         rx_get();
         chk("R1", $sformatf("rx order %0d", k), rx_rdata, pat(k, 32'h5000_0000));
      end
      rx_get();
      chk("R1", "pop empty keeps rdata", rx_rdata, pat(DEPTH - 1, 32'h5000_0000));
      chk("R1", "pop empty keeps count", 32'(rx_count), 0);
      chk("R3", "ovr still sticky", 32'(ovr_flag), 1);
      ovr_clr = 1'b1; step(); ovr_clr = 1'b0;
      chk("R3", "ovr cleared by write one", 32'(ovr_flag), 0);

      // interrupt gating (R9): rx count 1 with threshold 0, tx count 0 with threshold 7
      rx_thresh = 3'd0; tx_thresh = 3'd7;
      rx_put(32'h1111_1111);
      irq_en = 4'b0000; step();
      chk("R9", "all masked", 32'(irq), 0);
      irq_en = 4'b0001; step();
      chk("R9", "rx threshold only", 32'(irq), 32'b0001);
      irq_en = 4'b0010; step();
      chk("R9", "tx threshold only", 32'(irq), 32'b0010);
      irq_en = 4'b1111; step();
      chk("R9", "all enabled no flags", 32'(irq), 32'b0011);
      for (int k = 0; k < DEPTH; k++) rx_put(32'h2222_0000 + k);
      chk("R3", "second overrun", 32'(ovr_flag), 1);
      irq_en = 4'b0100; step();
      chk("R9", "overrun only", 32'(irq), 32'b0100);

      // clear priority over simultaneous push (R6)
      rx_clr = 1'b1; rx_push = 1'b1; rx_wdata = 32'h3333_3333; step();
      rx_clr = 1'b0; rx_push = 1'b0;
      chk("R6", "rx clear count", 32'(rx_count), 0);
      chk("R6", "rx clear flags", {rx_empty, rx_full}, 32'b10);
      ovr_clr = 1'b1; step(); ovr_clr = 1'b0;
      for (int k = 0; k < 3; k++) tx_put(32'h4444_0000 + k);
      tx_clr = 1'b1; tx_pop = 1'b1; step();
      tx_clr = 1'b0; tx_pop = 1'b0;
      chk("R6", "tx clear count", 32'(tx_count), 0);
      chk("R6", "tx clear flags", {tx_empty, tx_full}, 32'b10);
      chk("R6", "tx clear blocks pop", tx_rdata, pat(DEPTH - 1, 32'hA000_0000));

      // busy in master mode (R10)
      master_mode = 1'b1; engine_idle = 1'b0; step();
      chk("R10", "busy idle master", 32'(busy), 0);
      tx_put(32'h5555_0001);
      chk("R10", "busy after push", 32'(busy), 1);
      tx_put(32'h5555_0002);
      tx_get(); tx_get();
      chk("R10", "busy while engine active", 32'(busy), 1);
      chk("R10", "tx empty after drain", 32'(tx_empty), 1);
      engine_idle = 1'b1; step();
      chk("R10", "busy drops when drained and idle", 32'(busy), 0);
      master_mode = 1'b0; tx_put(32'h5555_0003);
      chk("R10", "no busy in slave mode", 32'(busy), 0);
      tx_clr = 1'b1; step(); tx_clr = 1'b0;

      // receive timeout (R7, R8)
      master_mode = 1'b1;
      ticks(70);
      chk("R7", "no timeout when empty", 32'(tmo_flag), 0);
      rx_put(32'h6666_0001);
      ticks(63);
      chk("R7", "no timeout after 63 ticks", 32'(tmo_flag), 0);
      ticks(1);
      chk("R7", "timeout after 64 ticks", 32'(tmo_flag), 1);
      irq_en = 4'b1000; step();
      chk("R9", "timeout only", 32'(irq), 32'b1000);
      rx_get();
      chk("R8", "read clears timeout", 32'(tmo_flag), 0);
      rx_put(32'h6666_0002);
      ticks(40);
      rx_put(32'h6666_0003);
      ticks(40);
      chk("R8", "push restarts count", 32'(tmo_flag), 0);
      ticks(24);
      chk("R8", "timeout after restart", 32'(tmo_flag), 1);
      tmo_clr = 1'b1; step(); tmo_clr = 1'b0;
      chk("R8", "write one clears timeout", 32'(tmo_flag), 0);
      ticks(70);
      chk("R8", "no refire without push or pop", 32'(tmo_flag), 0);
      master_mode = 1'b0;
      rx_get();
      ticks(70);
      chk("R7", "no timeout in slave mode", 32'(tmo_flag), 0);

      finish_run();
   end
endmodule